// File: doc/BRIEF.md
# Circular-Buffer FIR Filter Engine

This block turns a stream of audio-rate input samples into filtered output samples. It uses one multiply-accumulate unit and a tap loop that takes one clock per tap. A one-cycle input strobe starts a run. The engine first stores the incoming sample as the newest entry of a sample ring and clears its accumulator. It then walks all taps, reading one coefficient and one sample in the same cycle from two separate storage arrays. Both read pointers advance by one and wrap around the end of their arrays. The weighted sum is rounded and clamped to the output width and parked in a holding register. From there it is presented on the output port with a one-cycle valid pulse.

Coefficients are loaded through a plain write port while the engine is idle. A strobe that arrives during a run is reported on an overrun flag and that sample is discarded. The number of taps, the sample, coefficient and output widths, the fraction position and the rounding mode are parameters. The defaults are 16 taps, Q1.15 samples and coefficients, and round-half-up.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, `out_valid`, `busy` and `overrun` are 0 and `out_data` is 0. Every stored sample and every coefficient is 0, so the first runs yield 0 until coefficients are written.
- R2: A pulse on `coef_we` while `busy` is 0 stores `coef_data` as the coefficient at index `coef_addr`. Index 0 weights the newest sample and index k weights the sample k strobes older. A write with `coef_addr` >= TAPS changes nothing.
- R3: `in_valid` sampled while `busy` is 0 stores `in_data` as the newest sample, and `busy` is 1 from the next cycle on.
- R4: Each run produces y = sum over k in 0..TAPS-1 of c[k]*x[n-k]. Here x[n] is the sample of this strobe, older samples come from earlier accepted strobes, and never-written slots count as 0.
- R5: `out_valid` is high for exactly one cycle, TAPS+3 clock edges after the edge that sampled the accepted strobe. In that cycle `busy` is 0. `out_data` holds the result until the next result replaces it.
- R6: The full-precision sum is scaled down by 2^(CW-1), with 2^(CW-2) added first when ROUND_EN is 1 (round half up).
- R7: A scaled result above 2^(OW-1)-1 is output as 2^(OW-1)-1, and one below -2^(OW-1) is output as -2^(OW-1).
- R8: `in_valid` sampled while `busy` is 1 raises `overrun` for exactly the next cycle. That sample never enters the sample ring. `overrun` stays 0 for accepted strobes.
- R9: A coefficient write made while `busy` is 1 is ignored, and later runs use the earlier coefficient.
- R10: The accumulator is cleared at every accepted strobe, so no part of one result leaks into the next.
- R11: The sample ring holds exactly TAPS samples. Each accepted sample displaces the oldest one, including across the wrap of the write position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe announcing a new sample |
| in_data | input | DW | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | AW | Coefficient index, AW = clog2(TAPS) |
| coef_data | input | CW | Signed coefficient value |
| out_valid | output | 1 | One-cycle pulse when a new result is presented |
| out_data | output | OW | Rounded, saturated filter output |
| busy | output | 1 | High from strobe acceptance until the result is presented |
| overrun | output | 1 | One-cycle flag for a strobe dropped during a run |

## Verification
The bench runs a five-tap build of the engine, so the sample ring wraps many times. Impulse inputs show each coefficient at its own tap and so expose ordering or pointer-offset errors. Ramps, alternating-sign trains and random samples under several coefficient sets separate correct products from sign-extension and accumulation faults. Samples placed just above and below the half-LSB point show whether rounding is done or skipped. Full-scale inputs of both signs drive the clamp to both rails. Strobes and coefficient writes injected mid-run, followed by further runs, show whether a dropped sample or a locked-out coefficient leaked into the filter state.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

   // run sequencer states
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_LAST  = 3'd2,
      ST_HOLD  = 3'd3,
      ST_EMIT  = 3'd4
   } fir_state_e;

   // guard bits needed to sum n full-scale products
   function automatic int guard_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/fir_circ_ptr.sv
module fir_circ_ptr #(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter bit DOWN  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] ptr_q;
   logic [AW-1:0] ptr_nxt;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fir_circ_ptr: DEPTH must be at least 2");
      end
      if ((1 << AW) < DEPTH) begin : g_bad_aw
         $error("fir_circ_ptr: AW too narrow for DEPTH");
      end

      if (DOWN) begin : g_down
         always_comb begin
            if (ptr_q == '0) ptr_nxt = LAST;
            else             ptr_nxt = ptr_q - 1'b1;
         end
      end else begin : g_up
         always_comb begin
            if (ptr_q == LAST) ptr_nxt = '0;
            else               ptr_nxt = ptr_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    ptr_q <= '0;
      else if (load) ptr_q <= load_val;
      else if (step) ptr_q <= ptr_nxt;
   end

   assign ptr = ptr_q;

   AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val <= LAST) |=> (ptr_q <= LAST)); // R11

endmodule

// File: rtl/fir_tap_ram.sv
module fir_tap_ram #(
   parameter int DEPTH = 16,
   parameter int W     = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem_q [DEPTH];

   generate
      if (W < 2) begin : g_bad_w
         $error("fir_tap_ram: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   // asynchronous read: the word is usable in the cycle its address is set
   assign rdata = mem_q[raddr];

endmodule

// File: rtl/fir_mac_acc.sv
module fir_mac_acc #(
   parameter int A_W      = 16,
   parameter int B_W      = 16,
   parameter int ACC_W    = 36,
   parameter int SHIFT    = 15,
   parameter int OUT_W    = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    mul_en,
   input  logic                    hold_en,
   input  logic                    emit_en,
   input  logic signed [A_W-1:0]   a,
   input  logic signed [B_W-1:0]   b,
   output logic signed [OUT_W-1:0] out_data,
   output logic                    out_valid
);

   localparam int P_W = A_W + B_W;
   localparam int R_W = ACC_W + 1;
   localparam logic signed [OUT_W-1:0] MAX_N = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0] MIN_N = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic signed [R_W-1:0]   MAX_R = R_W'(MAX_N);
   localparam logic signed [R_W-1:0]   MIN_R = R_W'(MIN_N);

   logic signed [P_W-1:0]   prod_q;
   logic                    prod_v;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [R_W-1:0]   acc_ext;
   logic signed [R_W-1:0]   scaled;
   logic signed [OUT_W-1:0] sat_val;
   logic signed [OUT_W-1:0] hold_q;

   generate
      if (ACC_W < P_W) begin : g_bad_acc
         $error("fir_mac_acc: ACC_W narrower than a product");
      end
      if (SHIFT < 1 || SHIFT >= ACC_W) begin : g_bad_shift
         $error("fir_mac_acc: SHIFT out of range");
      end
      if (OUT_W > ACC_W) begin : g_bad_out
         $error("fir_mac_acc: OUT_W wider than accumulator");
      end
   endgenerate

   assign acc_ext = R_W'(acc_q);

   generate
      if (ROUND_EN) begin : g_round
         localparam logic signed [R_W-1:0] HALF = R_W'(1) <<< (SHIFT - 1);
         assign scaled = (acc_ext + HALF) >>> SHIFT;
      end else begin : g_trunc
         assign scaled = acc_ext >>> SHIFT;
      end
   endgenerate

   always_comb begin
      if (scaled > MAX_R)      sat_val = MAX_N;
      else if (scaled < MIN_R) sat_val = MIN_N;
      else                     sat_val = scaled[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_q    <= '0;
         prod_v    <= 1'b0;
         acc_q     <= '0;
         hold_q    <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         prod_v <= mul_en;
         if (mul_en) prod_q <= a * b;
         if (clr)         acc_q <= '0;
         else if (prod_v) acc_q <= acc_q + ACC_W'(prod_q);
         if (hold_en) hold_q <= sat_val;
         out_valid <= emit_en;
         if (emit_en) out_data <= hold_q;
      end
   end

   AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0)); // R10

   AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R5

   AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !emit_en |=> $stable(out_data)); // R5

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
   import fir_mac_pkg::*;
#(
   parameter int TAPS      = 16,
   parameter int DW        = 16,
   parameter int CW        = 16,
   parameter int OW        = DW,
   parameter int COEF_FRAC = CW - 1,
   parameter bit ROUND_EN  = 1'b1,
   parameter int AW        = (TAPS < 2) ? 1 : $clog2(TAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_data,
   input  logic                 coef_we,
   input  logic [AW-1:0]        coef_addr,
   input  logic signed [CW-1:0] coef_data,
   output logic                 out_valid,
   output logic signed [OW-1:0] out_data,
   output logic                 busy,
   output logic                 overrun
);

   localparam int            ACC_W    = DW + CW + guard_bits(TAPS);
   localparam logic [AW-1:0] LAST_TAP = AW'(TAPS - 1);

   generate
      if (TAPS < 2) begin : g_bad_taps
         $error("fir_mac_engine: TAPS must be at least 2");
      end
      if (AW != $clog2(TAPS)) begin : g_bad_aw
         $error("fir_mac_engine: AW must equal clog2(TAPS)");
      end
      if (COEF_FRAC < 1) begin : g_bad_frac
         $error("fir_mac_engine: COEF_FRAC must be positive");
      end
   endgenerate

   fir_state_e    state_q;
   fir_state_e    state_nxt;
   logic [AW-1:0] tap_q;
   logic          accept;
   logic          fetching;
   logic          coef_wr_ok;
   logic          overrun_q;
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] srd_ptr;
   logic [AW-1:0] crd_ptr;
   logic [DW-1:0] samp_rd;
   logic [CW-1:0] coef_rd;

   assign busy       = (state_q != ST_IDLE);
   assign accept     = in_valid && !busy;
   assign fetching   = (state_q == ST_FETCH);
   assign coef_wr_ok = coef_we && !busy && (coef_addr <= LAST_TAP);

   // sequencer
   always_comb begin
      state_nxt = state_q;
      unique case (state_q)
         ST_IDLE:  if (in_valid) state_nxt = ST_FETCH;
         ST_FETCH: if (tap_q == LAST_TAP) state_nxt = ST_LAST;
         ST_LAST:  state_nxt = ST_HOLD;
         ST_HOLD:  state_nxt = ST_EMIT;
         ST_EMIT:  state_nxt = ST_IDLE;
         default:  state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         tap_q     <= '0;
         overrun_q <= 1'b0;
      end else begin
         state_q   <= state_nxt;
         overrun_q <= in_valid && busy;
         if (accept)        tap_q <= '0;
         else if (fetching) tap_q <= tap_q + 1'b1;
      end
   end

   assign overrun = overrun_q;

   // newest sample is written at wr_ptr, which then moves down, so the
   // tap walk reads newest-to-oldest with an up-counting pointer
   fir_circ_ptr #(.DEPTH(TAPS), .AW(AW), .DOWN(1'b1)) u_wr_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (1'b0),
      .load_val ('0),
      .step     (accept),
      .ptr      (wr_ptr)
   );

   fir_circ_ptr #(.DEPTH(TAPS), .AW(AW), .DOWN(1'b0)) u_samp_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (wr_ptr),
      .step     (fetching),
      .ptr      (srd_ptr)
   );

   fir_circ_ptr #(.DEPTH(TAPS), .AW(AW), .DOWN(1'b0)) u_coef_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val ('0),
      .step     (fetching),
      .ptr      (crd_ptr)
   );

   fir_tap_ram #(.DEPTH(TAPS), .W(DW), .AW(AW)) u_samp_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (accept),
      .waddr (wr_ptr),
      .wdata (in_data),
      .raddr (srd_ptr),
      .rdata (samp_rd)
   );

   fir_tap_ram #(.DEPTH(TAPS), .W(CW), .AW(AW)) u_coef_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (coef_wr_ok),
      .waddr (coef_addr),
      .wdata (coef_data),
      .raddr (crd_ptr),
      .rdata (coef_rd)
   );

   fir_mac_acc #(
      .A_W      (DW),
      .B_W      (CW),
      .ACC_W    (ACC_W),
      .SHIFT    (COEF_FRAC),
      .OUT_W    (OW),
      .ROUND_EN (ROUND_EN)
   ) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .mul_en    (fetching),
      .hold_en   (state_q == ST_HOLD),
      .emit_en   (state_q == ST_EMIT),
      .a         ($signed(samp_rd)),
      .b         ($signed(coef_rd)),
      .out_data  (out_data),
      .out_valid (out_valid)
   );

   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !busy) |=> busy); // R3

   AST_BUSY_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(in_valid)); // R3

   AST_OVERRUN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && busy) |=> overrun); // R8

   AST_NO_OVERRUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !busy) |=> !overrun); // R8

   AST_OUT_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(state_q) == ST_EMIT) && !busy); // R5

   AST_FETCH_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      (fetching && tap_q != LAST_TAP) |=> fetching); // R4

endmodule

// File: tb/fir_mac_engine_test.sv
module fir_mac_engine_test;

   localparam int CLK_PERIOD = 10;
   localparam int TAPS       = 5;
   localparam int AW         = 3;
   localparam int LAT        = TAPS + 3;
   localparam int WATCHDOG   = 150000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               coef_we = 1'b0;
   logic [AW-1:0]      coef_addr = '0;
   logic signed [15:0] coef_data = '0;
   logic               out_valid;
   logic signed [15:0] out_data;
   logic               busy;
   logic               overrun;

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;
   int hist  [TAPS];
   int coefs [TAPS];

   always #(CLK_PERIOD/2) clk = ~clk;

   fir_mac_engine #(.TAPS(TAPS), .DW(16), .CW(16), .AW(AW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .coef_we   (coef_we),
      .coef_addr (coef_addr),
      .coef_data (coef_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .busy      (busy),
      .overrun   (overrun)
   );

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
            report();
         end
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model_out();
      longint s = 0;
      for (int k = 0; k < TAPS; k++) s += longint'(coefs[k]) * longint'(hist[k]);
      s = (s + 16384) >>> 15;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return int'(s);
   endfunction

   task automatic write_coef(input int idx, input int val);
      coef_we   = 1'b1;
      coef_addr = AW'(idx);
      coef_data = 16'(val);
      @(negedge clk);
      coef_we = 1'b0;
      if (idx < TAPS) coefs[idx] = val;
   endtask

   // inject: 0 none, 1 strobe during run, 2 coefficient write during run
   task automatic run_sample(input int x, input string req, input int inject);
      int exp;
      in_valid = 1'b1;
      in_data  = 16'(x);
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      exp = model_out();
      chk("R3 busy after strobe", longint'(busy), 1);
      chk("R8 no overrun on accept", longint'(overrun), 0);
      for (int i = 0; i < LAT - 1; i++) begin
         if (i == 2 && inject == 1) begin
            in_valid = 1'b1;
            in_data  = 16'sd12345;
         end
         if (i == 2 && inject == 2) begin
            coef_we   = 1'b1;
            coef_addr = '0;
            coef_data = 16'sd7777;
         end
         @(negedge clk);
         if (i == 2) begin
            in_valid = 1'b0;
            coef_we  = 1'b0;
            if (inject == 1) chk("R8 overrun raised", longint'(overrun), 1);
         end
         if (i == 3 && inject == 1) chk("R8 overrun one cycle", longint'(overrun), 0);
      end
      chk("R5 no early out_valid", longint'(out_valid), 0);
      @(negedge clk);
      chk("R5 out_valid at TAPS+3", longint'(out_valid), 1);
      chk("R5 busy low at output", longint'(busy), 0);
      chk(req, longint'(out_data), longint'(exp));
      @(negedge clk);
      chk("R5 out_valid pulse", longint'(out_valid), 0);
      chk("R5 out_data held", longint'(out_data), longint'(exp));
   endtask

   initial begin
      for (int k = 0; k < TAPS; k++) begin
         hist[k]  = 0;
         coefs[k] = 0;
      end
      repeat (3) @(negedge clk);
      chk("R1 out_valid reset", longint'(out_valid), 0);
      chk("R1 busy reset", longint'(busy), 0);
      chk("R1 overrun reset", longint'(overrun), 0);
      chk("R1 out_data reset", longint'(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: zero coefficients after reset give zero output
      run_sample(20000, "R1 zero coefficients", 0);

      // R2 R4 R11: impulse shows each tap in order across several wraps
      write_coef(0, 1000);
      write_coef(1, -2000);
      write_coef(2, 3000);
      write_coef(3, -4000);
      write_coef(4, 5000);
      for (int rep = 0; rep < 3; rep++) begin
         run_sample(32767, "R4 impulse head", 0);
         for (int k = 0; k < TAPS; k++) run_sample(0, "R11 impulse tail", 0);
      end

      // R2: out-of-range coefficient index changes nothing
      write_coef(7, 9999);
      write_coef(6, -9999);
      run_sample(32767, "R2 out-of-range index ignored", 0);

      // R4 R11: coefficient sets crossed with sample patterns
      for (int cs = 0; cs < 4; cs++) begin
         for (int k = 0; k < TAPS; k++) begin
            case (cs)
               0: write_coef(k, (k + 1) * 4000);
               1: write_coef(k, (k % 2 == 0) ? 12000 : -12000);
               2: write_coef(k, int'($signed(16'($urandom))));
               default: write_coef(k, 6553 - k * 3000);
            endcase
         end
         for (int p = 0; p < 3; p++) begin
            for (int n = 0; n < 12; n++) begin
               case (p)
                  0: run_sample(n * 2700 - 15000, "R4 ramp", 0);
                  1: run_sample((n % 2 == 0) ? 21000 : -21000, "R4 alternating", 0);
                  default: run_sample(int'($signed(16'($urandom))), "R11 random stream", 0);
               endcase
            end
         end
      end

      // R6: rounding about the half-LSB point, single unit coefficient
      write_coef(0, 1);
      for (int k = 1; k < TAPS; k++) write_coef(k, 0);
      run_sample(16384, "R6 half rounds up", 0);
      run_sample(16383, "R6 below half", 0);
      run_sample(-16384, "R6 negative half", 0);
      run_sample(-16385, "R6 below negative half", 0);
      run_sample(32767, "R6 near one", 0);

      // R7: clamp to both rails
      for (int k = 0; k < TAPS; k++) write_coef(k, 32767);
      for (int n = 0; n < TAPS; n++) run_sample(32767, "R7 positive clamp", 0);
      for (int n = 0; n < TAPS; n++) run_sample(-32768, "R7 negative clamp", 0);
      for (int k = 0; k < TAPS; k++) write_coef(k, -32768);
      run_sample(-32768, "R7 negative times negative clamp", 0);

      // R10: a saturated run must not leak into the next one
      for (int k = 0; k < TAPS; k++) write_coef(k, 0);
      run_sample(-32768, "R10 accumulator cleared", 0);
      write_coef(2, 8192);
      run_sample(100, "R10 fresh sum", 0);

      // R8: strobe during a run is dropped
      write_coef(0, 3000);
      write_coef(1, -7000);
      run_sample(9000, "R8 run with overrun", 1);
      for (int n = 0; n < TAPS; n++) run_sample(n * 1000 - 2000, "R8 history without dropped sample", 0);

      // R9: coefficient write during a run is ignored
      run_sample(15000, "R9 run with locked write", 2);
      run_sample(15000, "R9 old coefficient kept", 0);
      run_sample(-15000, "R9 old coefficient kept", 0);

      report();
   end

endmodule